// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the system reset for a supply supervisor. Two conditions can hold reset: a synchronous undervoltage flag from an external comparator and an asynchronous, active-low push-button input. Reset stays asserted while either condition is present. Once both are gone, reset stays asserted for a release delay and then drops. The delay is counted in millisecond ticks that a prescaler outside the block supplies.

A two-bit select input chooses the release delay from four values. The push-button input passes through a synchronizer and a glitch filter before it can act. The block drives reset in both polarities. It also emits single-cycle event pulses when undervoltage begins and when a filtered push-button press begins, so that a fault-capture register can record the cause.

Top module: `sup_reset_gen`

## Requirements
- R1: A high `uv_flag` sampled on a clock edge makes `rst_out` high and `rst_out_n` low from that edge onward, for as long as the flag stays high.
- R2: After every cause has cleared, reset is released on the clock edge of the Nth `ms_tick` that follows, where N is the selected delay. Ticks on the edge where the clear is first seen do not count.
- R3: While the filtered push-button input is active, reset stays asserted, however long the press lasts. After release, a full selected delay runs before reset drops. The release reaches the sequencer after 2 synchronizer flops, then FILT_LEN filter samples, then one sequencer edge.
- R4: The delay select codes are 2'b00 = 50 ticks, 2'b01 = 200 ticks, 2'b10 = 400 ticks and 2'b11 = 800 ticks.
- R5: While `rst_n` is low, reset is asserted. After `rst_n` rises, reset is held for 200 ticks (code 2'b01, the default) whatever `dly_sel` is, with ticks counted from the first edge.
- R6: A low pulse on `mr_n_async` that lasts fewer than FILT_LEN synchronized samples has no effect. Reset stays released and no `mr_evt` pulse is produced. The filter output changes only to the value its synchronized input holds.
- R7: `rst_out_n` is always the complement of `rst_out`.
- R8: A cause that appears while a release delay is running cancels that delay. When the cause clears, a full delay starts again from zero.
- R9: `uv_evt` pulses high for exactly one cycle when `uv_flag` rises. `mr_evt` pulses high for exactly one cycle when the filtered push-button input becomes active.
- R10: The delay select is sampled on the edge where the causes are first seen clear. Changes to `dly_sel` after that edge affect only the next delay period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on clear |
| uv_flag | input | 1 | Synchronous undervoltage flag, high when the supply is low |
| mr_n_async | input | 1 | Asynchronous active-low push-button reset |
| dly_sel | input | 2 | Release delay select code |
| ms_tick | input | 1 | One-cycle millisecond tick from the prescaler |
| rst_out_n | output | 1 | Active-low system reset |
| rst_out | output | 1 | Active-high system reset |
| uv_evt | output | 1 | One-cycle pulse when undervoltage begins |
| mr_evt | output | 1 | One-cycle pulse when a filtered push-button press begins |

## Verification
The bench counts its own ticks between the edge where a cause clears and the edge where reset drops. A counter that was off by one, or that counted the clearing edge, would release one tick early or late. A second cause raised halfway through a delay must push the release out by a full period; a design that resumed the old count would release about half a delay early. Changing the select code during a delay checks the sampling point: a design that read the live select would stretch a 50-tick delay to 800. A sub-threshold button glitch must leave reset low and produce no event, and a design whose filter was one sample short would pulse reset. The power-up delay is measured with the select code held at 2'b11, so a design that ignored the default would release at 800 ticks instead of 200.

// File: rtl/sup_rst_pkg.sv
`timescale 1ns/1ps
package sup_rst_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_t;

  localparam logic [1:0] SEL_DEFAULT = 2'b01;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned pick_delay(input logic [1:0] sel,
                                             input int unsigned d0, input int unsigned d1,
                                             input int unsigned d2, input int unsigned d3);
    unique case (sel)
      2'b00:   return d0;
      2'b01:   return d1;
      2'b10:   return d2;
      default: return d3;
    endcase
  endfunction

endpackage

// File: rtl/mr_conditioner.sv
`timescale 1ns/1ps
module mr_conditioner #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_async,
  output logic sync_act,
  output logic mr_act
);
  localparam int unsigned FCNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [FCNT_W-1:0] FCNT_LAST = FCNT_W'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] chain;
  logic [FCNT_W-1:0]      fcnt;

  if (SYNC_STAGES == 1) begin : g_sync_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= mr_n_async;
    end
  end else begin : g_sync_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[SYNC_STAGES-2:0], mr_n_async};
    end
  end

  assign sync_act = ~chain[SYNC_STAGES-1];

  // The filtered level follows the synchronized one only after FILT_LEN agreeing samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_act <= 1'b0;
      fcnt   <= '0;
    end else if (sync_act != mr_act) begin
      if (fcnt == FCNT_LAST) begin
        mr_act <= sync_act;
        fcnt   <= '0;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end else begin
      fcnt <= '0;
    end
  end
endmodule

// File: rtl/rise_pulse.sv
`timescale 1ns/1ps
module rise_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      prev  <= level;
      pulse <= level & ~prev;
    end
  end
endmodule

// File: rtl/release_timer.sv
`timescale 1ns/1ps
module release_timer import sup_rst_pkg::*; #(
  parameter int unsigned D_SEL0 = 50,
  parameter int unsigned D_SEL1 = 200,
  parameter int unsigned D_SEL2 = 400,
  parameter int unsigned D_SEL3 = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] sel_in,
  output logic [1:0] active_sel,
  output logic       expire
);
  localparam int unsigned MAX_D = max_of4(D_SEL0, D_SEL1, D_SEL2, D_SEL3);
  localparam int unsigned CNT_W = $clog2(MAX_D + 1);

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] last_count(input logic [1:0] s);
    return CNT_W'(pick_delay(s, D_SEL0, D_SEL1, D_SEL2, D_SEL3) - 1);
  endfunction

  assign expire = run && tick && (cnt == last_count(active_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      active_sel <= SEL_DEFAULT;
    end else if (load) begin
      cnt        <= '0;
      active_sel <= sel_in;
    end else if (expire) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sup_reset_gen.sv
`timescale 1ns/1ps
module sup_reset_gen import sup_rst_pkg::*; #(
  parameter int unsigned D_SEL0      = 50,
  parameter int unsigned D_SEL1      = 200,
  parameter int unsigned D_SEL2      = 400,
  parameter int unsigned D_SEL3      = 800,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uv_flag,
  input  logic       mr_n_async,
  input  logic [1:0] dly_sel,
  input  logic       ms_tick,
  output logic       rst_out_n,
  output logic       rst_out,
  output logic       uv_evt,
  output logic       mr_evt
);
  seq_state_t state, state_nx;
  logic       mr_act, mr_sync_act, cause;
  logic       tmr_load, tmr_run, tmr_expire;
  logic [1:0] active_sel;

  mr_conditioner #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_mr (
    .clk(clk), .rst_n(rst_n), .mr_n_async(mr_n_async),
    .sync_act(mr_sync_act), .mr_act(mr_act)
  );

  rise_pulse u_uv_edge (.clk(clk), .rst_n(rst_n), .level(uv_flag), .pulse(uv_evt));
  rise_pulse u_mr_edge (.clk(clk), .rst_n(rst_n), .level(mr_act),  .pulse(mr_evt));

  assign cause    = uv_flag | mr_act;
  assign tmr_load = (state == ST_HOLD);
  assign tmr_run  = (state == ST_DELAY) && !cause;

  release_timer #(.D_SEL0(D_SEL0), .D_SEL1(D_SEL1), .D_SEL2(D_SEL2), .D_SEL3(D_SEL3)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run), .tick(ms_tick),
    .sel_in(dly_sel), .active_sel(active_sel), .expire(tmr_expire)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_HOLD:  if (!cause) state_nx = ST_DELAY;
      ST_DELAY: if (cause) state_nx = ST_HOLD;
                else if (tmr_expire) state_nx = ST_RUN;
      ST_RUN:   if (cause) state_nx = ST_HOLD;
      default:  state_nx = ST_HOLD;
    endcase
  end

  // Power-up begins in the delay phase so the default period runs before first release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_DELAY;
      rst_out   <= 1'b1;
      rst_out_n <= 1'b0;
    end else begin
      state     <= state_nx;
      rst_out   <= (state_nx != ST_RUN);
      rst_out_n <= (state_nx == ST_RUN);
    end
  end
endmodule

// File: rtl/sup_reset_gen_chk.sv
`timescale 1ns/1ps
module sup_reset_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uv_flag,
  input logic       ms_tick,
  input logic       rst_out,
  input logic       rst_out_n,
  input logic       uv_evt,
  input logic       mr_evt,
  input logic       mr_act,
  input logic       mr_sync_act,
  input logic       tmr_run,
  input logic [1:0] active_sel
);
  AST_UV_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> rst_out); // R1
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> $past(ms_tick)); // R2
  AST_MR_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    mr_act |=> rst_out); // R3
  AST_FILTER_TRACKS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_act != $past(mr_act)) |-> (mr_act == $past(mr_sync_act))); // R6
  AST_POLARITY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_n != rst_out); // R7
  AST_UV_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    uv_evt |=> !uv_evt); // R9
  AST_MR_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mr_evt |=> !mr_evt); // R9
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_run && $past(tmr_run)) |-> $stable(active_sel)); // R10
endmodule

bind sup_reset_gen sup_reset_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .ms_tick(ms_tick),
  .rst_out(rst_out), .rst_out_n(rst_out_n), .uv_evt(uv_evt), .mr_evt(mr_evt),
  .mr_act(mr_act), .mr_sync_act(mr_sync_act), .tmr_run(tmr_run), .active_sel(active_sel)
);

// File: tb/sup_reset_gen_tb.sv
`timescale 1ns/1ps
module sup_reset_gen_tb;
  localparam int TICK_DIV = 4;
  localparam int SYNC_N   = 2;
  localparam int FILT_N   = 4;
  localparam int MR_LAT   = SYNC_N + FILT_N + 1;

  // {select code, expected ticks} from R4
  localparam logic [11:0] VEC [4] = '{
    {2'b00, 10'd50}, {2'b01, 10'd200}, {2'b10, 10'd400}, {2'b11, 10'd800}
  };

  logic clk = 1'b0;
  logic rst_n, uv_flag, mr_n_async, ms_tick;
  logic [1:0] dly_sel;
  logic rst_out_n, rst_out, uv_evt, mr_evt;

  int n_chk = 0, n_err = 0;
  int n_uv = 0, n_mr = 0, pol_bad = 0;
  int div = 0;

  always #10 clk = ~clk;

  sup_reset_gen #(.SYNC_STAGES(SYNC_N), .FILT_LEN(FILT_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .mr_n_async(mr_n_async),
    .dly_sel(dly_sel), .ms_tick(ms_tick), .rst_out_n(rst_out_n), .rst_out(rst_out),
    .uv_evt(uv_evt), .mr_evt(mr_evt)
  );

  initial ms_tick = 1'b0;
  always @(negedge clk) begin
    div     <= (div == TICK_DIV - 1) ? 0 : div + 1;
    ms_tick <= (div == TICK_DIV - 2);
  end

  always @(negedge clk) begin
    if (uv_evt) n_uv++;
    if (mr_evt) n_mr++;
    if (rst_n && (rst_out_n == rst_out)) pol_bad++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts ticks seen after edge first_idx until reset drops; returns via check.
  task automatic measure(input int first_idx, input int exp_ticks, input string req,
                         input int chg_idx, input logic [1:0] chg_val);
    int ticks = 0;
    int got = -1;
    int limit = first_idx + exp_ticks * TICK_DIV + 40;
    for (int idx = 1; idx <= limit; idx++) begin
      logic t;
      @(posedge clk);
      t = ms_tick;
      #1;
      if (idx > first_idx && t) ticks++;
      if (idx == chg_idx) dly_sel = chg_val;
      if (!rst_out) begin
        got = ticks;
        break;
      end
    end
    chk(req, got, exp_ticks);
  endtask

  initial begin
    rst_n = 1'b0; uv_flag = 1'b0; mr_n_async = 1'b1; dly_sel = 2'b11;
    repeat (5) @(negedge clk);
    chk("R5 reset asserted in clear", int'(rst_out), 1);
    chk("R7 low output in clear", int'(rst_out_n), 0);
    rst_n = 1'b1;
    measure(0, 200, "R5 power-up default delay", 0, 2'b00);
    @(negedge clk);

    for (int v = 0; v < 4; v++) begin
      int uv0;
      uv0 = n_uv;
      dly_sel = VEC[v][11:10];
      uv_flag = 1'b1;
      @(posedge clk); #1;
      chk("R1 reset follows undervoltage", int'(rst_out), 1);
      repeat (20) @(negedge clk);
      chk("R1 reset held during undervoltage", int'(rst_out), 1);
      chk("R9 one uv event per rise", n_uv - uv0, 1);
      uv_flag = 1'b0;
      measure(1, int'(VEC[v][9:0]), "R2 R4 table delay", 0, 2'b00);
      @(negedge clk);
    end

    // R10: select changes mid-delay apply only to the next period
    dly_sel = 2'b00; uv_flag = 1'b1;
    repeat (3) @(negedge clk);
    uv_flag = 1'b0;
    measure(1, 50, "R10 mid-delay select change ignored", 20, 2'b11);
    @(negedge clk);
    uv_flag = 1'b1;
    repeat (3) @(negedge clk);
    uv_flag = 1'b0;
    measure(1, 800, "R10 new select used next period", 0, 2'b11);
    @(negedge clk);

    // R8: a new cause during the delay restarts it in full
    dly_sel = 2'b01; uv_flag = 1'b1;
    repeat (3) @(negedge clk);
    uv_flag = 1'b0;
    repeat (100 * TICK_DIV) @(negedge clk);
    chk("R8 still in delay", int'(rst_out), 1);
    uv_flag = 1'b1;
    repeat (3) @(negedge clk);
    uv_flag = 1'b0;
    measure(1, 200, "R8 restarted full delay", 0, 2'b01);
    @(negedge clk);

    // R3: long push-button hold, then full delay after release
    begin
      int mr0;
      mr0 = n_mr;
      dly_sel = 2'b00;
      mr_n_async = 1'b0;
      repeat (400) @(negedge clk);
      chk("R3 reset held while button low", int'(rst_out), 1);
      chk("R9 one mr event per press", n_mr - mr0, 1);
      mr_n_async = 1'b1;
      measure(MR_LAT, 50, "R3 delay after button release", 0, 2'b00);
      @(negedge clk);
    end

    // R6: glitch one sample short of the filter length
    begin
      int mr0, hi;
      mr0 = n_mr; hi = 0;
      mr_n_async = 1'b0;
      repeat (FILT_N - 1) @(negedge clk);
      mr_n_async = 1'b1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (rst_out) hi++;
      end
      chk("R6 glitch leaves reset released", hi, 0);
      chk("R6 glitch gives no mr event", n_mr - mr0, 0);
    end

    chk("R7 outputs complementary throughout", pol_bad, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired, run incomplete (R2)");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule